// File: doc/BRIEF.md
# UART Interrupt Flag Controller

This block gathers the interrupt causes of a UART-style serial port. It keeps one status flag for each cause and one enable bit for each interrupt class, and it drives a single interrupt request line. The transmit and receive datapaths feed it single-cycle strobes. One strobe marks a transmit word moving into the shift register. The others mark a received word landing in the receive buffer, a parity error and a framing error. The block detects an overrun on its own: a new received word arrives while the receive-full flag is still pending.

Software reaches the block through a small register port. The port has a status register, an enable register and a 3-bit mode field. Writing all zeros to the mode field acts as a software reset: it returns every flag, every enable and the mode field to its initial value. This is also the only way to clear the overrun flag. The request line is the OR of three gated terms: transmit-empty, receive-full, and the three error flags combined under one error enable.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After the hardware reset, the status, enable and mode registers all read 0, and `irq_o` is low.
- R2: A one-cycle pulse on `ev_tx_moved` sets status bit 0 (transmit empty) at the next clock edge, whether or not its enable is set.
- R3: A pulse on `ev_rx_loaded` sets status bit 1 (receive full) at the next clock edge, whether or not its enable is set.
- R4: A pulse on `ev_parity_err` sets status bit 2, and a pulse on `ev_frame_err` sets status bit 3, at the next clock edge.
- R5: A pulse on `ev_rx_loaded` while status bit 1 is already set also sets status bit 4 (overrun). Writing 1 to bit 4 of the status register leaves it set.
- R6: Writing the status register (address 0) clears each of bits 0 to 3 that is written as 1. Bits written as 0 keep their value.
- R7: When a set strobe and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: `irq_o` is high exactly when one of these holds: bit 0 and enable bit 0 are both set, bit 1 and enable bit 1 are both set, or any of status bits 2 to 4 is set while enable bit 2 is set. It rises in the same cycle that the gating flag or enable becomes visible.
- R9: The enable register (address 1) keeps write data bits [2:0]. The mode register (address 2) keeps write data bits [2:0]. Both read back what was written.
- R10: Writing 0 to the mode register clears all five flags, all enable bits and the mode field. This write takes priority over any event strobe in the same cycle, and `irq_o` is low from the next cycle on.
- R11: A read asserted in one cycle places that register's value, zero-extended to 8 bits, on `reg_rdata` after the next clock edge. The value reflects state from before any write in the same cycle. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_moved | input | 1 | Strobe: transmit buffer moved into the shift register |
| ev_rx_loaded | input | 1 | Strobe: received word loaded into the receive buffer |
| ev_parity_err | input | 1 | Strobe: parity error on reception |
| ev_frame_err | input | 1 | Strobe: framing error on reception |
| reg_wr | input | 1 | Register write enable |
| reg_rd | input | 1 | Register read enable |
| reg_addr | input | 2 | Register address (0 status, 1 enable, 2 mode) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Shared interrupt request |

## Verification
Each flag and enable is registered once. A strobe or write driven in one cycle therefore becomes visible one edge later. `irq_o` is combinational from those registers, so it changes in that same cycle. A read of the status register takes one more edge to appear on `reg_rdata`. The bench drives every input on the falling clock edge and holds it across exactly one rising edge. It then samples `irq_o` at the next falling edge. For register contents, it issues a read and samples `reg_rdata` one falling edge after that read. Same-cycle collisions are driven in a single falling-edge slot so that they share one rising edge: a set strobe against a clear, and a strobe against the software reset.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int REG_DW      = 8;
    localparam int REG_AW      = 2;
    localparam int NUM_FLAGS   = 5;
    localparam int NUM_CLASSES = 3;
    localparam int MODE_W      = 3;

    localparam logic [REG_AW-1:0] ADDR_STAT = 2'd0;
    localparam logic [REG_AW-1:0] ADDR_EN   = 2'd1;
    localparam logic [REG_AW-1:0] ADDR_MODE = 2'd2;

    localparam int FB_TXE = 0;
    localparam int FB_RXF = 1;
    localparam int FB_PAR = 2;
    localparam int FB_FRM = 3;
    localparam int FB_OVR = 4;
    localparam int NUM_W1C = FB_FRM + 1;

    localparam int CL_TX  = 0;
    localparam int CL_RX  = 1;
    localparam int CL_ERR = 2;

    typedef logic [NUM_FLAGS-1:0]   flag_vec_t;
    typedef logic [NUM_CLASSES-1:0] class_vec_t;
    typedef logic [MODE_W-1:0]      mode_t;
endpackage

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank
    import uirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sw_rst,
    input  logic                  ev_tx,
    input  logic                  ev_rx,
    input  logic                  ev_par,
    input  logic                  ev_frm,
    input  logic [REG_DW-1:0]     clr_mask,
    output flag_vec_t             flags_o
);
    typedef struct packed {
        flag_vec_t flags;
    } bank_st_t;

    bank_st_t st_d, st_q;
    flag_vec_t set_vec;

    logic unused_clr;
    assign unused_clr = ^clr_mask[REG_DW-1:NUM_W1C];

    always_comb begin
        set_vec         = '0;
        set_vec[FB_TXE] = ev_tx;
        set_vec[FB_RXF] = ev_rx;
        set_vec[FB_PAR] = ev_par;
        set_vec[FB_FRM] = ev_frm;
        set_vec[FB_OVR] = ev_rx && st_q.flags[FB_RXF];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_W1C; i++) begin
            if (set_vec[i])          st_d.flags[i] = 1'b1;
            else if (clr_mask[i])    st_d.flags[i] = 1'b0;
        end
        if (set_vec[FB_OVR]) st_d.flags[FB_OVR] = 1'b1;
        if (sw_rst) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    AST_TX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_tx && !sw_rst) |=> flags_o[FB_TXE]); // R2

    AST_RX_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rx && !sw_rst) |=> flags_o[FB_RXF]); // R3

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[FB_OVR] && !sw_rst) |=> flags_o[FB_OVR]); // R5

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frm && clr_mask[FB_FRM] && !sw_rst) |=> flags_o[FB_FRM]); // R7

    AST_SWRST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (flags_o == '0)); // R10

    for (genvar g = 0; g < NUM_W1C; g++) begin : g_w1c_chk
        AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[g] && !set_vec[g]) |=> !flags_o[g]); // R6
    end
endmodule

// File: rtl/uirq_cfg_regs.sv
module uirq_cfg_regs
    import uirq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_AW-1:0]     addr,
    input  logic [REG_DW-1:0]     wdata,
    output class_vec_t            en_o,
    output mode_t                 mode_o,
    output logic                  sw_rst_o
);
    typedef struct packed {
        class_vec_t en;
        mode_t      mode;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata[REG_DW-1:MODE_W];

    assign sw_rst_o = wr_en && (addr == ADDR_MODE) && (wdata[MODE_W-1:0] == '0);

    always_comb begin
        st_d = st_q;
        if (wr_en && addr == ADDR_EN)   st_d.en   = wdata[NUM_CLASSES-1:0];
        if (wr_en && addr == ADDR_MODE) st_d.mode = wdata[MODE_W-1:0];
        if (sw_rst_o) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign mode_o = st_q.mode;

    AST_SWRST_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_o |=> (en_o == '0 && mode_o == '0)); // R10

    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_o)); // R9
endmodule

// File: rtl/uirq_req_combine.sv
module uirq_req_combine
    import uirq_pkg::*;
(
    input  flag_vec_t  flags,
    input  class_vec_t en,
    output logic       irq_o
);
    class_vec_t cls_pend;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_class
        if (c == CL_TX) begin : g_tx
            assign cls_pend[c] = flags[FB_TXE];
        end else if (c == CL_RX) begin : g_rx
            assign cls_pend[c] = flags[FB_RXF];
        end else begin : g_err
            assign cls_pend[c] = flags[FB_PAR] | flags[FB_FRM] | flags[FB_OVR];
        end
    end

    assign irq_o = |(cls_pend & en);

    always_comb begin
        AST_ERR_CLASS_GATED: assert ((en[CL_ERR] && (flags[FB_OVR] || flags[FB_PAR])) -> irq_o); // R8
    end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_tx_moved,
    input  logic              ev_rx_loaded,
    input  logic              ev_parity_err,
    input  logic              ev_frame_err,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq_o
);
    typedef struct packed {
        logic [REG_DW-1:0] rdata;
    } top_st_t;

    top_st_t    st_d, st_q;
    flag_vec_t  flags;
    class_vec_t en;
    mode_t      mode;
    logic       sw_rst;
    logic [REG_DW-1:0] clr_mask;

    assign clr_mask = (reg_wr && reg_addr == ADDR_STAT) ? reg_wdata : '0;

    uirq_cfg_regs u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .en_o     (en),
        .mode_o   (mode),
        .sw_rst_o (sw_rst)
    );

    uirq_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_rst   (sw_rst),
        .ev_tx    (ev_tx_moved),
        .ev_rx    (ev_rx_loaded),
        .ev_par   (ev_parity_err),
        .ev_frm   (ev_frame_err),
        .clr_mask (clr_mask),
        .flags_o  (flags)
    );

    uirq_req_combine u_req (
        .flags (flags),
        .en    (en),
        .irq_o (irq_o)
    );

    always_comb begin
        st_d = st_q;
        if (reg_rd) begin
            st_d.rdata = '0;
            unique case (reg_addr)
                ADDR_STAT: st_d.rdata[NUM_FLAGS-1:0]   = flags;
                ADDR_EN:   st_d.rdata[NUM_CLASSES-1:0] = en;
                ADDR_MODE: st_d.rdata[MODE_W-1:0]      = mode;
                default:   st_d.rdata                  = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;

    AST_IRQ_DROPS_AFTER_SWRST: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !irq_o); // R10

    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata)); // R11

    AST_NO_IRQ_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o); // R8
endmodule

// File: tb/uart_irq_ctrl_bench.sv
`timescale 1ns/1ps
module uart_irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_tx_moved = 1'b0, ev_rx_loaded = 1'b0;
    logic       ev_parity_err = 1'b0, ev_frame_err = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_tx_moved(ev_tx_moved), .ev_rx_loaded(ev_rx_loaded),
        .ev_parity_err(ev_parity_err), .ev_frame_err(ev_frame_err),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic strobe(input bit tx, input bit rx, input bit par, input bit frm);
        ev_tx_moved = tx; ev_rx_loaded = rx; ev_parity_err = par; ev_frame_err = frm;
        @(negedge clk);
        ev_tx_moved = 0; ev_rx_loaded = 0; ev_parity_err = 0; ev_frame_err = 0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 irq", int'(irq_o), 0);
        rd(2'd0, v); check("R1 status", v, 8'h00);
        rd(2'd1, v); check("R1 enable", v, 8'h00);
        rd(2'd2, v); check("R1 mode", v, 8'h00);
    endtask

    task automatic t_tx_path();
        logic [7:0] v;
        strobe(1, 0, 0, 0);
        check("R8 irq masked", int'(irq_o), 0);
        rd(2'd0, v); check("R2 tx flag", v, 8'h01);
        wr(2'd1, 8'h01);
        check("R8 irq on enable", int'(irq_o), 1);
        rd(2'd1, v); check("R9 enable readback", v, 8'h01);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R6 write0 no effect", v, 8'h01);
        wr(2'd0, 8'h01);
        check("R6 irq after clear", int'(irq_o), 0);
        rd(2'd0, v); check("R6 tx cleared", v, 8'h00);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        strobe(1, 0, 0, 0);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h01; ev_tx_moved = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; ev_tx_moved = 1'b0;
        rd(2'd0, v); check("R7 set beats clear", v, 8'h01);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_rx_overrun();
        logic [7:0] v;
        strobe(0, 1, 0, 0);
        rd(2'd0, v); check("R3 rx flag", v, 8'h02);
        strobe(0, 1, 0, 0);
        rd(2'd0, v); check("R5 overrun set", v, 8'h12);
        wr(2'd0, 8'h12);
        rd(2'd0, v); check("R5 overrun sticky", v, 8'h10);
        check("R8 no irq err disabled", int'(irq_o), 0);
        wr(2'd1, 8'h04);
        check("R8 irq from overrun", int'(irq_o), 1);
        wr(2'd2, 8'h00);
        check("R10 irq low after swrst", int'(irq_o), 0);
        rd(2'd0, v); check("R10 flags cleared", v, 8'h00);
        rd(2'd1, v); check("R10 enables cleared", v, 8'h00);
    endtask

    task automatic t_errors();
        logic [7:0] v;
        wr(2'd1, 8'h04);
        strobe(0, 0, 1, 0);
        check("R8 irq from parity", int'(irq_o), 1);
        rd(2'd0, v); check("R4 parity flag", v, 8'h04);
        wr(2'd0, 8'h04);
        check("R6 irq after parity clear", int'(irq_o), 0);
        strobe(0, 0, 0, 1);
        check("R8 irq from framing", int'(irq_o), 1);
        rd(2'd0, v); check("R4 framing flag", v, 8'h08);
        wr(2'd0, 8'h08);
        rd(2'd0, v); check("R6 framing cleared", v, 8'h00);
        wr(2'd1, 8'h02);
        strobe(0, 1, 0, 0);
        check("R8 irq from rx", int'(irq_o), 1);
        wr(2'd0, 8'h02);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_mode_regs();
        logic [7:0] v;
        wr(2'd2, 8'hFD);
        rd(2'd2, v); check("R9 mode readback", v, 8'h05);
        rd(2'd3, v); check("R11 addr3 zero", v, 8'h00);
        strobe(1, 0, 0, 0);
        reg_rd = 1'b1; reg_addr = 2'd0; reg_wr = 1'b1; reg_wdata = 8'h01;
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        check("R11 read sees pre-write", int'(reg_rdata), 8'h01);
        wr(2'd1, 8'h07);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h00; ev_rx_loaded = 1'b1; ev_tx_moved = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_rx_loaded = 1'b0; ev_tx_moved = 1'b0;
        check("R10 irq low", int'(irq_o), 0);
        rd(2'd0, v); check("R10 swrst beats event", v, 8'h00);
        rd(2'd2, v); check("R10 mode cleared", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_path();
        t_set_wins();
        t_rx_overrun();
        t_errors();
        t_mode_regs();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule